// File: doc/BRIEF.md
# Serial Flash Slave Front End

This block is the serial-bus side of a flash memory device acting as a SPI slave. It watches chip select, serial clock, serial data in, hold and write-protect, and turns a selection into array requests. Each selection carries an 8-bit opcode and a 24-bit address, both sent most significant bit first. A read then streams array bytes out on the serial output. A program streams bytes in, one write request per byte. An erase issues a single request for the address.

All pins are oversampled by a fast system clock `clk` that must run well above the serial clock. Serial edges are found by comparing registered copies of the pins. Program and erase are checked against a protected top region of the array, chosen by a 3-bit field `bp`. While `wp_n` is low, a command that lands in that region is refused with a reject pulse. The array itself, its timing and multi-line I/O belong to other blocks.

Top module: `sflash_front`

## Requirements
- R1: Serial input is sampled on rising serial clock edges. The first 8 bits of a selection form the opcode and the next 24 bits the address, both MSB first. Opcode 0x03 is read, 0x02 is program and 0xD8 is erase. Any other opcode produces no request, no reject and no output for the rest of that selection.
- R2: Read, part one. After the last address bit, `mem_rd` pulses for one cycle with `mem_addr` holding the address. `rd_data` is taken in that same cycle.
- R2 (continued): On each later falling serial edge, `so` presents the next data bit, MSB first, starting at the falling edge that follows the last address bit. Consecutive bytes come from consecutive addresses.
- R3: `so_oe` is low while chip select is high. It is high only during the data phase of a read.
- R4: After reset, nothing is accepted until chip select has had a falling edge. A transfer already under way at reset is ignored.
- R5: While `hold_n` and `cs_n` are both low, `so_oe` is low and serial clock and serial input activity is ignored. The transfer resumes with its state intact once hold is released.
- R6: A rising edge of chip select abandons any partial transfer. The next selection starts with a new opcode.
- R7: Protected region by `bp`. A value of 0 protects nothing and 7 protects the whole array. A value n from 1 to 6 protects the top 1/2^(7-n) of the address space, so 1 protects the top 1/64 and 6 protects the top half.
- R8: Program. Each completed data byte gives a one-cycle `mem_wr` pulse, with `wr_data` holding the byte and `mem_addr` its address. The address then steps by one.
- R9: Erase. When the address is complete, `erase_req` pulses for one cycle with `mem_addr` holding the address.
- R10: A program or erase whose address lies in the protected region while `wp_n` is low gives a single one-cycle `reject` pulse and no `mem_wr` or `erase_req` for that selection. With `wp_n` high, protection has no effect.
- R11: `standby` is high exactly when chip select is high and `array_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold, active low, effective only while selected |
| wp_n | input | 1 | Write protect, active low |
| bp | input | 3 | Protected-region selector |
| array_busy | input | 1 | Array has a program, erase or status write in progress |
| rd_data | input | 8 | Array byte at `mem_addr`, taken in the `mem_rd` cycle |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| mem_rd | output | 1 | One-cycle read request |
| mem_wr | output | 1 | One-cycle program request |
| mem_addr | output | 24 | Array address for the current request |
| wr_data | output | 8 | Byte to program |
| erase_req | output | 1 | One-cycle erase request |
| reject | output | 1 | One-cycle pulse for a refused program or erase |
| standby | output | 1 | Device deselected and idle |

## Verification
The bench goes after the region boundaries for several `bp` values, one address on each side of each bound. A wrong shift in the region compare lets a write through or refuses a legal one. Hold is raised in the middle of an address and in the middle of a read stream while the clock keeps toggling. A block that listened during hold would corrupt the address or skip read bytes. The bench also starts with chip select already low at reset, and it abandons a selection after five opcode bits. Missing arming or a bit counter that is not cleared would each produce a spurious request or a shifted opcode. Random mixes of opcode, address, `bp` and `wp_n` cover the remaining combinations against a bench model of region and data.

// File: rtl/sflash_front.sv
module sflash_front #(
  parameter int ADDR_W = 24,
  parameter logic [7:0] OP_READ  = 8'h03,
  parameter logic [7:0] OP_PROG  = 8'h02,
  parameter logic [7:0] OP_ERASE = 8'hD8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic              wp_n,
  input  logic [2:0]        bp,
  input  logic              array_busy,
  input  logic [7:0]        rd_data,
  output logic              so,
  output logic              so_oe,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        wr_data,
  output logic              erase_req,
  output logic              reject,
  output logic              standby
);
  localparam int CW = $clog2(ADDR_W);
  localparam logic [CW-1:0] LAST_BIT  = CW'(7);
  localparam logic [CW-1:0] LAST_ADDR = CW'(ADDR_W - 1);

  typedef enum logic [1:0] {P_OP, P_ADDR, P_DATA, P_IGN} phase_t;

  logic s_cs_n, p_cs_n, s_sck, p_sck, s_si, s_hold_n, s_wp_n;
  logic armed, out_on, so_q;
  phase_t phase;
  logic [CW-1:0] cnt;
  logic [7:0] op, rd_byte;
  logic [6:0] osh;
  logic [2:0] ocnt;
  logic [ADDR_W-1:0] sh, next_sh;

  function automatic logic in_region(input logic [ADDR_W-1:0] a, input logic [2:0] f);
    logic [ADDR_W-1:0] lim;
    if (f == 3'd0) return 1'b0;
    if (f == 3'd7) return 1'b1;
    lim = ~({ADDR_W{1'b1}} >> (7 - f));
    return (a & lim) == lim;
  endfunction

  function automatic logic known_op(input logic [7:0] o);
    return (o == OP_READ) || (o == OP_PROG) || (o == OP_ERASE);
  endfunction

  wire held    = !s_hold_n && !s_cs_n;
  wire live    = armed && !s_cs_n && !held;
  wire rise    = live && s_sck && !p_sck;
  wire fall    = live && !s_sck && p_sck;
  wire cs_fall = !s_cs_n && p_cs_n;
  wire blocked = !s_wp_n && in_region(next_sh, bp);

  assign next_sh = {sh[ADDR_W-2:0], s_si};
  assign so      = so_q;
  assign so_oe   = live && out_on && (phase == P_DATA);
  assign standby = s_cs_n && !array_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs_n <= 1'b0; p_cs_n <= 1'b0;
      s_sck <= 1'b0;  p_sck <= 1'b0;
      s_si <= 1'b0;   s_hold_n <= 1'b1; s_wp_n <= 1'b1;
      armed <= 1'b0;  out_on <= 1'b0;   so_q <= 1'b0;
      phase <= P_OP;  cnt <= '0;        op <= '0;
      sh <= '0;       osh <= '0;        ocnt <= '0;
      rd_byte <= '0;  mem_addr <= '0;   wr_data <= '0;
      mem_rd <= 1'b0; mem_wr <= 1'b0;   erase_req <= 1'b0; reject <= 1'b0;
    end else begin
      s_cs_n <= cs_n;   p_cs_n <= s_cs_n;
      s_sck <= sck;     p_sck <= s_sck;
      s_si <= si;       s_hold_n <= hold_n; s_wp_n <= wp_n;
      mem_rd <= 1'b0; mem_wr <= 1'b0; erase_req <= 1'b0; reject <= 1'b0;
      if (mem_rd) rd_byte <= rd_data;
      if (mem_wr) mem_addr <= mem_addr + 1'b1;
      if (cs_fall) armed <= 1'b1;
      if (s_cs_n) begin
        phase <= P_OP; cnt <= '0; out_on <= 1'b0; ocnt <= '0;
      end else if (rise) begin
        case (phase)
          P_OP: begin
            sh <= next_sh;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              op <= next_sh[7:0];
              phase <= known_op(next_sh[7:0]) ? P_ADDR : P_IGN;
            end
          end
          P_ADDR: begin
            sh <= next_sh;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_ADDR) begin
              cnt <= '0;
              mem_addr <= next_sh;
              if (op == OP_READ) begin
                mem_rd <= 1'b1;
                phase <= P_DATA;
              end else if (blocked) begin
                reject <= 1'b1;
                phase <= P_IGN;
              end else if (op == OP_PROG) begin
                phase <= P_DATA;
              end else begin
                erase_req <= 1'b1;
                phase <= P_IGN;
              end
            end
          end
          P_DATA: begin
            if (op == OP_PROG) begin
              sh <= next_sh;
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                cnt <= '0;
                mem_wr <= 1'b1;
                wr_data <= next_sh[7:0];
              end
            end
          end
          default: ;
        endcase
      end else if (fall && phase == P_DATA && op == OP_READ) begin
        out_on <= 1'b1;
        ocnt <= ocnt + 1'b1;
        if (ocnt == 3'd0) begin
          so_q <= rd_byte[7];
          osh <= rd_byte[6:0];
          mem_addr <= mem_addr + 1'b1;
          mem_rd <= 1'b1;
        end else begin
          so_q <= osh[6];
          osh <= {osh[5:0], 1'b0};
        end
      end
    end
  end
endmodule

module sflash_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic hold_n,
  input logic armed,
  input logic so_oe,
  input logic mem_rd,
  input logic mem_wr,
  input logic erase_req,
  input logic reject,
  input logic standby
);
  a_r3_oe_off_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !so_oe);
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n && $past(!hold_n && !cs_n)) |-> !so_oe);
  a_r4_no_cmd_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !(mem_rd || mem_wr || erase_req || reject));
  a_r10_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject);
  a_r10_reject_excl: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !(mem_wr || erase_req));
  a_r9_erase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  a_r11_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !so_oe);
endmodule

bind sflash_front sflash_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .armed(armed),
  .so_oe(so_oe), .mem_rd(mem_rd), .mem_wr(mem_wr), .erase_req(erase_req),
  .reject(reject), .standby(standby)
);

// File: tb/sflash_front_bench.sv
module sflash_front_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic [2:0] bp = 3'd0;
  logic array_busy = 1'b0;
  logic [7:0] rd_data, wr_data;
  logic so, so_oe, mem_rd, mem_wr, erase_req, reject, standby;
  logic [23:0] mem_addr;
  int total = 0, bad = 0;
  int nwr = 0, ner = 0, nrej = 0;
  logic [23:0] wlog_a [0:255];
  logic [7:0]  wlog_d [0:255];
  logic [23:0] elog_a;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] model_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic bit exp_prot(input logic [23:0] a, input logic [2:0] f);
    int unsigned size;
    size = 32'd1 << 24;
    if (f == 3'd0) return 1'b0;
    if (f == 3'd7) return 1'b1;
    return {8'd0, a} >= size - (size >> (7 - f));
  endfunction

  assign rd_data = model_byte(mem_addr);

  sflash_front u_sflash_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .bp(bp), .array_busy(array_busy), .rd_data(rd_data),
    .so(so), .so_oe(so_oe), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .wr_data(wr_data), .erase_req(erase_req), .reject(reject), .standby(standby)
  );

  always @(negedge clk) if (rst_n) begin
    if (mem_wr) begin
      wlog_a[nwr % 256] = mem_addr;
      wlog_d[nwr % 256] = wr_data;
      nwr++;
    end
    if (erase_req) begin
      elog_a = mem_addr;
      ner++;
    end
    if (reject) nrej++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic ob, output logic oe);
    sck = 1'b0; si = b; clk_n(4);
    ob = so; oe = so_oe;
    sck = 1'b1; clk_n(4);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r, output logic any_oe, output logic all_oe);
    logic ob, oe;
    any_oe = 1'b0; all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sbit(b[i], ob, oe);
      r[i] = ob; any_oe |= oe; all_oe &= oe;
    end
  endtask

  task automatic select_dev();
    sck = 1'b0; clk_n(2); cs_n = 1'b0; clk_n(4);
  endtask

  task automatic deselect_dev();
    sck = 1'b0; clk_n(4); cs_n = 1'b1; clk_n(6);
  endtask

  task automatic send_head(input logic [7:0] op, input logic [23:0] a, output logic any_oe);
    logic [7:0] r; logic ao, al;
    xbyte(op, r, ao, al); any_oe = ao;
    xbyte(a[23:16], r, ao, al); any_oe |= ao;
    xbyte(a[15:8], r, ao, al); any_oe |= ao;
    xbyte(a[7:0], r, ao, al); any_oe |= ao;
  endtask

  task automatic run_txn(input logic [7:0] op, input logic [23:0] a, input logic [2:0] f,
                         input logic wp, input int nb);
    int w0, e0, j0;
    logic any_oe, ao, al;
    logic [7:0] r, d;
    logic [7:0] dat [0:3];
    bit prot;
    bp = f; wp_n = wp; clk_n(2);
    select_dev();
    w0 = nwr; e0 = ner; j0 = nrej;
    send_head(op, a, any_oe);
    check(!any_oe, "R3 oe low before data", any_oe, 0);
    for (int k = 0; k < nb; k++) begin
      d = 8'($urandom);
      dat[k] = d;
      xbyte(d, r, ao, al);
      if (op == 8'h03) begin
        check(r == model_byte(a + 24'(k)), "R2 read byte", r, model_byte(a + 24'(k)));
        check(al, "R3 oe high in read data", al, 1);
      end else begin
        check(!ao, "R3 oe low outside read", ao, 0);
      end
    end
    deselect_dev();
    check(!so_oe, "R3 oe low deselected", so_oe, 0);
    prot = !wp && exp_prot(a, f);
    if (op == 8'h02) begin
      if (prot) begin
        check(nrej - j0 == 1, "R10 program reject", nrej - j0, 1);
        check(nwr == w0, "R10 no write when protected", nwr - w0, 0);
      end else begin
        check(nrej == j0, "R7 program allowed", nrej - j0, 0);
        check(nwr - w0 == nb, "R8 write count", nwr - w0, nb);
        for (int k = 0; k < nb && k < nwr - w0; k++) begin
          check(wlog_a[(w0 + k) % 256] == a + 24'(k), "R8 write addr", wlog_a[(w0 + k) % 256], a + 24'(k));
          check(wlog_d[(w0 + k) % 256] == dat[k], "R8 write data", wlog_d[(w0 + k) % 256], dat[k]);
        end
      end
    end else if (op == 8'hD8) begin
      if (prot) begin
        check(nrej - j0 == 1, "R10 erase reject", nrej - j0, 1);
        check(ner == e0, "R10 no erase when protected", ner - e0, 0);
      end else begin
        check(ner - e0 == 1 && nrej == j0, "R9 erase issued", ner - e0, 1);
        check(elog_a == a, "R9 erase addr", elog_a, a);
      end
    end else begin
      check(nwr == w0 && ner == e0 && nrej == j0, "R1 no action", (nwr - w0) + (ner - e0) + (nrej - j0), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic any_oe, ob, oe;
    int e0, w0, j0;
    logic [7:0] r; logic ao, al;
    logic [7:0] ops [0:3];
    void'($urandom(32'd1234));
    ops[0] = 8'h03; ops[1] = 8'h02; ops[2] = 8'hD8; ops[3] = 8'h9F;
    clk_n(5); rst_n = 1'b1; clk_n(3);
    check(!so_oe && !mem_wr && !reject && !erase_req && !mem_rd, "R3 reset state", so_oe, 0);
    check(!standby, "R11 standby low while selected", standby, 0);

    // R4: selected at reset; erase must be ignored
    e0 = ner; j0 = nrej;
    send_head(8'hD8, 24'h001000, any_oe);
    deselect_dev();
    check(ner == e0 && nrej == j0, "R4 unarmed ignores erase", ner - e0, 0);

    // R11
    check(standby, "R11 standby when deselected", standby, 0);
    array_busy = 1'b1; clk_n(2);
    check(!standby, "R11 busy clears standby", standby, 1);
    array_busy = 1'b0; clk_n(2);
    check(standby, "R11 idle standby", standby, 0);

    run_txn(8'hD8, 24'h001000, 3'd0, 1'b1, 0);

    // R6: abort after five opcode bits
    select_dev();
    for (int i = 0; i < 5; i++) sbit(1'b1, ob, oe);
    deselect_dev();
    run_txn(8'h02, 24'h012345, 3'd0, 1'b0, 2);

    // R7 / R10 boundaries
    run_txn(8'h02, 24'h7FFFFF, 3'd6, 1'b0, 1);
    run_txn(8'h02, 24'h800000, 3'd6, 1'b0, 1);
    run_txn(8'hD8, 24'hFBFFFF, 3'd1, 1'b0, 0);
    run_txn(8'hD8, 24'hFC0000, 3'd1, 1'b0, 0);
    run_txn(8'hD8, 24'hBFFFFF, 3'd5, 1'b0, 0);
    run_txn(8'hD8, 24'hC00000, 3'd5, 1'b0, 0);
    run_txn(8'h02, 24'h000000, 3'd7, 1'b0, 1);
    run_txn(8'h02, 24'h000000, 3'd7, 1'b1, 1);
    run_txn(8'h03, 24'hFFFFFE, 3'd7, 1'b0, 3);
    run_txn(8'h9F, 24'h000010, 3'd0, 1'b1, 2);

    // R5: hold in address phase of a program
    bp = 3'd0; wp_n = 1'b1; clk_n(2);
    select_dev();
    w0 = nwr;
    xbyte(8'h02, r, ao, al);
    xbyte(8'h00, r, ao, al);
    sck = 1'b0; clk_n(4);
    hold_n = 1'b0; clk_n(3);
    for (int i = 0; i < 4; i++) begin
      si = 1'($urandom); sck = 1'b1; clk_n(4); sck = 1'b0; clk_n(4);
    end
    hold_n = 1'b1; clk_n(3);
    xbyte(8'h40, r, ao, al);
    xbyte(8'h00, r, ao, al);
    xbyte(8'h5C, r, ao, al);
    deselect_dev();
    check(nwr - w0 == 1, "R5 one write after hold", nwr - w0, 1);
    check(wlog_a[w0 % 256] == 24'h004000, "R5 address kept across hold", wlog_a[w0 % 256], 24'h004000);
    check(wlog_d[w0 % 256] == 8'h5C, "R5 data after hold", wlog_d[w0 % 256], 8'h5C);

    // R5: hold in read stream
    select_dev();
    send_head(8'h03, 24'h00ABCD, any_oe);
    xbyte(8'h00, r, ao, al);
    check(r == model_byte(24'h00ABCD), "R2 read before hold", r, model_byte(24'h00ABCD));
    sck = 1'b0; clk_n(2);
    hold_n = 1'b0; clk_n(3);
    check(!so_oe, "R5 oe low in hold", so_oe, 0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; clk_n(4); sck = 1'b0; clk_n(4);
      check(!so_oe, "R5 oe stays low in hold", so_oe, 0);
    end
    hold_n = 1'b1; clk_n(3);
    xbyte(8'h00, r, ao, al);
    check(r == model_byte(24'h00ABCE), "R5 read resumes in order", r, model_byte(24'h00ABCE));
    deselect_dev();

    // hold toggled while deselected has no effect
    hold_n = 1'b0; clk_n(4); hold_n = 1'b1; clk_n(2);
    run_txn(8'hD8, 24'h123456, 3'd0, 1'b0, 0);

    // random mix (R1, R2, R7, R8, R9, R10)
    for (int t = 0; t < 40; t++) begin
      run_txn(ops[$urandom % 4], 24'($urandom), 3'($urandom), 1'($urandom), 1 + ($urandom % 3));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule